// File: doc/BRIEF.md
# Banked Memory Mapper with Line-Count Interrupt

This block sits between a processor write port and the address-extension logic of a cartridge. It holds eight bank numbers, loaded through an index/data register pair, and turns them into four 8 KB program-memory slot numbers and eight 1 KB pattern-memory slot numbers. Two mode bits rearrange the slots. One mode bit swaps the two 4 KB halves of pattern space. The other chooses which 8 KB program window is fixed to the second-to-last bank. A separate bit selects horizontal or vertical nametable mirroring.

A down counter is advanced by an external once-per-line pulse. When the counter is already zero, the pulse reloads it from a software-written latch and, if the interrupt is enabled, raises a level interrupt. The interrupt stays high until software writes the disable location. All register access is by write strobes in the upper half of the 16-bit address space. Address bit 0 picks one of two registers within each 8 KB region.

Top module: `scanIrqMapper`

## Requirements
- R1: After reset the program slots are banks 0, 1, PRG_BANKS-2 and PRG_BANKS-1 (slots 0 to 3). The pattern slots 0 to 7 read 0,1,0,1,0,0,0,0. Mirroring is vertical (0), the interrupt is low and disabled, and both the counter and the latch hold 255.
- R2: A write to an even address in 0x8000-0x9FFF loads the index/mode register. Bits 2:0 give the target bank register, bit 6 is the program mode and bit 7 is the pattern inversion. A write to an odd address in that range stores the data byte into the bank register the index names.
- R3: With inversion 0, pattern slots 0 to 7 are B0, B0+1, B1, B1+1, B2, B3, B4, B5, where the +1 wraps modulo 256.
- R4: With inversion 1, the two halves trade places, so pattern slots 0 to 7 are B2, B3, B4, B5, B0, B0+1, B1, B1+1.
- R5: With program mode 0, program slots 0 to 3 are B6, B7, second-last, last. With mode 1 they are second-last, B7, B6, last.
- R6: B6 and B7 are reduced to their low log2(PRG_BANKS) bits before they are placed in a program slot.
- R7: A write to an even address in 0xA000-0xBFFF sets mirrorHoriz from data bit 0, where 1 means horizontal. A write to an odd address there leaves mirroring unchanged.
- R8: An even write in 0xC000-0xDFFF loads the reload latch. An odd write there zeroes the counter. An even write in 0xE000-0xFFFF disables the interrupt and drops irqOut. An odd write there enables the interrupt.
- R9: On a lineTick, a nonzero counter decrements. A zero counter reloads from the latch and sets irqOut if the interrupt was enabled before that edge. irqOut never rises without a lineTick.
- R10: irqOut stays high until a disable write. A disable write in the same cycle as a raising tick leaves irqOut low.
- R11: A counter-clear write in the same cycle as a lineTick leaves the counter at zero, so the next tick raises the interrupt.
- R12: Writes with address bit 15 clear change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Processor write strobe, one cycle per write |
| wrAddr | input | 16 | Processor write address |
| wrData | input | 8 | Processor write data |
| lineTick | input | 1 | One-cycle pulse per display line |
| prgBanks | output | 4*log2(PRG_BANKS) | Program slot bank numbers, slot i at [i*W +: W] |
| chrBanks | output | 8*CHR_W | Pattern slot bank numbers, slot i at [i*CHR_W +: CHR_W] |
| mirrorHoriz | output | 1 | 1 = horizontal mirroring, 0 = vertical |
| irqOut | output | 1 | Level interrupt request |

## Verification
A processor write to the counter or interrupt registers can land in the same cycle as a line pulse. The bench provokes this by driving a write and lineTick together. In one case a disable write coincides with a tick that would raise the interrupt, and irqOut is expected to stay low. In the other a counter clear coincides with a decrementing tick, and the result is judged one tick later: the interrupt must rise there, which it would not do if the decrement had won.

// File: rtl/mapPkg.sv
package mapPkg;
  localparam int NUM_REGS = 8;

  // One-cycle decoded write strobes, control -> datapath
  typedef struct packed {
    logic selWr;    // index/mode register
    logic dataWr;   // bank register named by the index
    logic mirWr;    // mirroring
    logic latchWr;  // reload latch
    logic cntClr;   // counter clear
    logic irqOff;   // disable + acknowledge
    logic irqOn;    // enable
  } mapStrobes_t;
endpackage

// File: rtl/mapCtrl.sv
module mapCtrl
  import mapPkg::*;
(
  input  logic       wrEn,
  input  logic [2:0] region,   // address bits 15:13
  input  logic       oddAddr,  // address bit 0
  output mapStrobes_t strobes
);
  logic hit;
  assign hit = wrEn && region[2];

  always_comb begin
    strobes = '0;
    if (hit) begin
      unique case (region[1:0])
        2'b00: begin strobes.selWr   = !oddAddr; strobes.dataWr = oddAddr; end
        2'b01: begin strobes.mirWr   = !oddAddr; end
        2'b10: begin strobes.latchWr = !oddAddr; strobes.cntClr = oddAddr; end
        default: begin strobes.irqOff = !oddAddr; strobes.irqOn = oddAddr; end
      endcase
    end
  end
endmodule

// File: rtl/mapBanks.sv
module mapBanks
  import mapPkg::*;
#(
  parameter int PRG_BANKS = 16,
  parameter int CHR_W     = 8,
  localparam int PRG_W    = $clog2(PRG_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mapStrobes_t          strobes,
  input  logic [7:0]           wrData,
  output logic [4*PRG_W-1:0]   prgBanks,
  output logic [8*CHR_W-1:0]   chrBanks,
  output logic                 mirrorHoriz
);
  logic [7:0] bankReg [NUM_REGS];
  logic [2:0] regIdx;
  logic       prgMode;
  logic       chrInv;
  logic       mirror;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) bankReg[i] <= (i == 7) ? 8'd1 : 8'd0;
      regIdx  <= '0;
      prgMode <= 1'b0;
      chrInv  <= 1'b0;
      mirror  <= 1'b0;
    end else begin
      if (strobes.selWr) begin
        regIdx  <= wrData[2:0];
        prgMode <= wrData[6];
        chrInv  <= wrData[7];
      end
      if (strobes.dataWr) bankReg[regIdx] <= wrData;
      if (strobes.mirWr)  mirror <= wrData[0];
    end
  end

  assign mirrorHoriz = mirror;

  // Pattern slots: logical slot = physical slot with bit 2 flipped on inversion
  for (genvar s = 0; s < 8; s++) begin : g_chr
    logic [2:0] logSlot;
    logic [7:0] pick;
    always_comb begin
      logSlot = 3'(s) ^ {chrInv, 2'b00};
      if (!logSlot[2]) pick = bankReg[{2'b00, logSlot[1]}] + {7'd0, logSlot[0]};
      else             pick = bankReg[3'(logSlot - 3'd2)];
    end
    assign chrBanks[s*CHR_W +: CHR_W] = CHR_W'(pick);
  end

  // Program slots
  localparam logic [PRG_W-1:0] LAST_BANK = PRG_W'(PRG_BANKS - 1);
  localparam logic [PRG_W-1:0] PREV_BANK = PRG_W'(PRG_BANKS - 2);
  logic [PRG_W-1:0] swA, swB;
  assign swA = bankReg[6][PRG_W-1:0];
  assign swB = bankReg[7][PRG_W-1:0];

  assign prgBanks[0*PRG_W +: PRG_W] = prgMode ? PREV_BANK : swA;
  assign prgBanks[1*PRG_W +: PRG_W] = swB;
  assign prgBanks[2*PRG_W +: PRG_W] = prgMode ? swA : PREV_BANK;
  assign prgBanks[3*PRG_W +: PRG_W] = LAST_BANK;

  logic unusedHigh;
  assign unusedHigh = ^{bankReg[6][7:PRG_W], bankReg[7][7:PRG_W]};
endmodule

// File: rtl/lineIrq.sv
module lineIrq
  import mapPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  mapStrobes_t strobes,
  input  logic [7:0]  wrData,
  input  logic        lineTick,
  output logic        irqOut
);
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] reload;
  logic             enabled;
  logic             irqQ;
  logic             atZero;

  assign atZero = (count == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '1;
      reload  <= '1;
      enabled <= 1'b0;
      irqQ    <= 1'b0;
    end else begin
      if (strobes.latchWr) reload <= CNT_W'(wrData);

      if (strobes.cntClr)      count <= '0;
      else if (lineTick)       count <= atZero ? reload : count - CNT_W'(1);

      if (strobes.irqOff)      enabled <= 1'b0;
      else if (strobes.irqOn)  enabled <= 1'b1;

      if (strobes.irqOff)                         irqQ <= 1'b0;
      else if (lineTick && atZero && enabled)     irqQ <= 1'b1;
    end
  end

  assign irqOut = irqQ;
endmodule

// File: rtl/scanIrqMapper.sv
module scanIrqMapper
  import mapPkg::*;
#(
  parameter int PRG_BANKS = 16,
  parameter int CHR_W     = 8,
  parameter int CNT_W     = 8,
  localparam int PRG_W    = $clog2(PRG_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [15:0]          wrAddr,
  input  logic [7:0]           wrData,
  input  logic                 lineTick,
  output logic [4*PRG_W-1:0]   prgBanks,
  output logic [8*CHR_W-1:0]   chrBanks,
  output logic                 mirrorHoriz,
  output logic                 irqOut
);
  mapStrobes_t strobes;

  logic unusedAddr;
  assign unusedAddr = ^wrAddr[12:1];

  mapCtrl uCtrl (
    .wrEn    (wrEn),
    .region  (wrAddr[15:13]),
    .oddAddr (wrAddr[0]),
    .strobes (strobes)
  );

  mapBanks #(.PRG_BANKS(PRG_BANKS), .CHR_W(CHR_W)) uBanks (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrData      (wrData),
    .prgBanks    (prgBanks),
    .chrBanks    (chrBanks),
    .mirrorHoriz (mirrorHoriz)
  );

  lineIrq #(.CNT_W(CNT_W)) uIrq (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (wrData),
    .lineTick (lineTick),
    .irqOut   (irqOut)
  );
endmodule

// File: rtl/mapChecker.sv
module mapChecker #(
  parameter int PRG_BANKS = 16,
  parameter int CHR_W     = 8,
  localparam int PRG_W    = $clog2(PRG_BANKS)
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [15:0]        wrAddr,
  input logic               lineTick,
  input logic [4*PRG_W-1:0] prgBanks,
  input logic [8*CHR_W-1:0] chrBanks,
  input logic               mirrorHoriz,
  input logic               irqOut
);
  logic offWr, mirWr, lowWr;
  assign offWr = wrEn && (wrAddr[15:13] == 3'b111) && !wrAddr[0];
  assign mirWr = wrEn && (wrAddr[15:13] == 3'b101) && !wrAddr[0];
  assign lowWr = wrEn && !wrAddr[15];

  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !offWr) |=> irqOut);

  p_irq_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    offWr |=> !irqOut);

  p_irq_needs_tick_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!irqOut && !lineTick) |=> !irqOut);

  p_mirror_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !mirWr |=> $stable(mirrorHoriz));

  p_low_ignored_r12: assert property (@(posedge clk) disable iff (!rstN)
    lowWr |=> ($stable(prgBanks) && $stable(chrBanks) && $stable(mirrorHoriz)));

  // R3 / R4: a pair always appears in one half or the other
  p_chr_pair_r3: assert property (@(posedge clk) disable iff (!rstN)
    (chrBanks[CHR_W +: 8] == 8'(chrBanks[0 +: 8] + 8'd1)) ||
    (chrBanks[5*CHR_W +: 8] == 8'(chrBanks[4*CHR_W +: 8] + 8'd1)));
endmodule

bind scanIrqMapper mapChecker #(.PRG_BANKS(PRG_BANKS), .CHR_W(CHR_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .wrAddr      (wrAddr),
  .lineTick    (lineTick),
  .prgBanks    (prgBanks),
  .chrBanks    (chrBanks),
  .mirrorHoriz (mirrorHoriz),
  .irqOut      (irqOut)
);

// File: tb/tb_scanIrqMapper.sv
`timescale 1ns/1ps
module tb_scanIrqMapper;
  localparam int PRG_BANKS = 16;
  localparam int PRG_W     = 4;
  localparam int CHR_W     = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic lineTick = 1'b0;
  logic [4*PRG_W-1:0] prgBanks;
  logic [8*CHR_W-1:0] chrBanks;
  logic mirrorHoriz;
  logic irqOut;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  scanIrqMapper #(.PRG_BANKS(PRG_BANKS), .CHR_W(CHR_W), .CNT_W(8)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .lineTick(lineTick), .prgBanks(prgBanks), .chrBanks(chrBanks),
    .mirrorHoriz(mirrorHoriz), .irqOut(irqOut)
  );

  // Bench model of the bank registers
  logic [7:0] mr [8];
  logic       mMode, mInv;

  function automatic logic [15:0] expPrg();
    logic [3:0] a, b;
    a = mr[6][3:0];
    b = mr[7][3:0];
    if (!mMode) return {4'd15, 4'd14, b, a};
    else        return {4'd15, a, b, 4'd14};
  endfunction

  function automatic logic [63:0] expChr();
    logic [7:0] lo [4];
    logic [7:0] hi [4];
    lo[0] = mr[0]; lo[1] = mr[0] + 8'd1; lo[2] = mr[1]; lo[3] = mr[1] + 8'd1;
    hi[0] = mr[2]; hi[1] = mr[3];        hi[2] = mr[4]; hi[3] = mr[5];
    if (!mInv) return {hi[3], hi[2], hi[1], hi[0], lo[3], lo[2], lo[1], lo[0]};
    else       return {lo[3], lo[2], lo[1], lo[0], hi[3], hi[2], hi[1], hi[0]};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 8; i++) mr[i] = (i == 7) ? 8'd1 : 8'd0;
    mMode = 1'b0;
    mInv  = 1'b0;
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d, input logic tick);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d; lineTick = tick;
    @(negedge clk);
    wrEn = 1'b0; lineTick = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    lineTick = 1'b1;
    @(negedge clk);
    lineTick = 1'b0;
  endtask

  initial begin
    logic [7:0] vals [5];
    logic [15:0] prgHold;
    logic [63:0] chrHold;
    vals[0] = 8'h00; vals[1] = 8'h01; vals[2] = 8'h5A; vals[3] = 8'hFF; vals[4] = 8'h37;

    doReset();
    // R1 reset state
    check("R1 prg reset", 64'(prgBanks), 64'({4'd15, 4'd14, 4'd1, 4'd0}));
    check("R1 chr reset", chrBanks, 64'h0000000001000100);
    check("R1 mirror reset", 64'(mirrorHoriz), 64'd0);
    check("R1 irq reset", 64'(irqOut), 64'd0);

    // R2 R3 R4 R5 R6 sweep over modes, registers and values
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 8; r++) begin
        for (int v = 0; v < 5; v++) begin
          busWrite(16'h8000 + 16'(v * 2), {m[1], m[0], 3'b000, 3'(r)}, 1'b0);
          mInv = m[1]; mMode = m[0];
          busWrite(16'h9FFF, vals[v] ^ 8'(r * 8'h11), 1'b0);
          mr[r] = vals[v] ^ 8'(r * 8'h11);
          check("R2 R5 R6 prg map", 64'(prgBanks), 64'(expPrg()));
          check("R2 R3 R4 chr map", chrBanks, expChr());
        end
      end
    end

    // R7 mirroring
    busWrite(16'hA000, 8'h01, 1'b0);
    check("R7 mirror horizontal", 64'(mirrorHoriz), 64'd1);
    busWrite(16'hA001, 8'h00, 1'b0);
    check("R7 odd write ignored", 64'(mirrorHoriz), 64'd1);
    busWrite(16'hBFFE, 8'hFE, 1'b0);
    check("R7 mirror vertical", 64'(mirrorHoriz), 64'd0);

    // R12 low writes ignored
    prgHold = prgBanks;
    chrHold = chrBanks;
    busWrite(16'h0000, 8'hC7, 1'b0);
    busWrite(16'h0001, 8'h99, 1'b0);
    busWrite(16'h2000, 8'h01, 1'b0);
    busWrite(16'h7FFF, 8'h42, 1'b0);
    check("R12 prg unchanged", 64'(prgBanks), 64'(prgHold));
    check("R12 chr unchanged", chrBanks, chrHold);
    check("R12 mirror unchanged", 64'(mirrorHoriz), 64'd0);

    // R9 counter starts at 255 after reset: 256th tick raises
    doReset();
    busWrite(16'hE001, 8'h00, 1'b0);
    repeat (255) pulse();
    check("R9 no irq after 255 ticks", 64'(irqOut), 64'd0);
    pulse();
    check("R9 irq on 256th tick", 64'(irqOut), 64'd1);

    // R10 sticky
    repeat (3) pulse();
    check("R10 irq held", 64'(irqOut), 64'd1);
    busWrite(16'hE000, 8'h00, 1'b0);
    check("R8 disable drops irq", 64'(irqOut), 64'd0);

    // R8 latch, clear, enable
    busWrite(16'hC000, 8'd3, 1'b0);
    busWrite(16'hC001, 8'h00, 1'b0);
    busWrite(16'hE001, 8'h00, 1'b0);
    pulse();  // counter 0 -> reload 3, raise
    check("R8 R9 clear then tick raises", 64'(irqOut), 64'd1);
    busWrite(16'hE000, 8'h00, 1'b0);
    busWrite(16'hE001, 8'h00, 1'b0);
    for (int k = 0; k < 3; k++) begin
      pulse();
      check("R9 decrement no irq", 64'(irqOut), 64'd0);
    end
    pulse();  // counter was 0: reload 3, raise
    check("R9 reload raises", 64'(irqOut), 64'd1);

    // R10 disable write with a raising tick in the same cycle
    busWrite(16'hE000, 8'h00, 1'b0);
    busWrite(16'hE001, 8'h00, 1'b0);
    repeat (3) pulse();  // counter 3 -> 0
    check("R10 not yet raised", 64'(irqOut), 64'd0);
    busWrite(16'hE000, 8'h00, 1'b1);  // reload to 3, disable wins
    check("R10 disable beats raise", 64'(irqOut), 64'd0);

    // R11 clear write with a decrementing tick in the same cycle
    busWrite(16'hE001, 8'h00, 1'b0);
    pulse();                          // 3 -> 2
    busWrite(16'hC001, 8'h00, 1'b1);  // clear wins over 2 -> 1
    check("R11 no irq at clear", 64'(irqOut), 64'd0);
    pulse();
    check("R11 clear beats decrement", 64'(irqOut), 64'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule